// File: doc/BRIEF.md
# Interrupt Redirection Servicing Engine

This block sits between a bank of external interrupt lines and the interrupt fabric of a processor complex. It holds one 64-bit redirection entry per pin. The entry sets the vector, delivery mode, destination mode, trigger mode, mask and a 16-bit destination for that pin. The block keeps a pending bit for every pin. It scans the pending, unmasked pins continuously and turns each deliverable request into a message-signalled interrupt: a 32-bit address and a 32-bit data word, presented on a valid/ready handshake.

Edge-triggered pins latch a rising input only while unmasked. The pending bit is cleared when the message is taken. Level-triggered pins track their input. Once delivered, a level pin sets a remote-acknowledge bit, and while that bit is set further requests from the pin are coalesced. An end-of-interrupt broadcast carrying a vector clears the acknowledge bit of every entry that holds that vector. If the line is still asserted and unmasked, the request is delivered again.

Software programs the entries through a parallel port that reads and writes one whole entry per cycle. Input line 0 is steered to pin 2. Input lines with no matching pin are ignored.

Top module: `irqsvc_engine`

## Requirements
- R1: After reset, every entry reads back as 64'h0000_0000_0001_0000 (only the mask bit 16 set) and no message is offered.
- R2: A rising edge on input line 0 acts as a request on pin 2, never on pin 0. Lines numbered at or above the pin count (24) have no effect.
- R3: On an edge pin (entry bit 15 = 0) whose mask (bit 16) is clear, a rising input produces exactly one message. A rising input seen while the pin is masked is dropped, and clearing the mask afterwards produces no message.
- R4: On a level pin (bit 15 = 1), a delivered request sets the remote-acknowledge bit (bit 14). While that bit is set, no further message comes from the pin. A low input clears the pin's pending state.
- R5: An end-of-interrupt with vector V clears bit 14 only on entries whose vector (bits 7:0) equals V. If such a pin is still asserted and unmasked, it is delivered again.
- R6: The message address is 32'hFEE0_0000 with the entry's destination (bits 63:48) placed at address bits 19:4 and the destination mode (bit 11) at address bit 2.
- R7: The message data carries the vector in bits 7:0, the delivery mode (entry bits 10:8) in bits 10:8 and the trigger mode in bit 15. All other data bits are zero.
- R8: When several pins are deliverable, the lowest-numbered pin is sent first. While ready is low, the offered message and its valid stay unchanged.
- R9: Entry writes leave bits 12 and 14 untouched and store zero in bits 17 to 47. A write that selects edge mode clears bit 14.
- R10: A level pin asserted while masked stays pending and is delivered once its mask is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_INPUTS (32) | Raw interrupt request lines |
| entIdx | input | $clog2(NUM_PINS) (5) | Entry selected for read and write |
| entWrEn | input | 1 | Write the selected entry this cycle |
| entWrData | input | 64 | New entry value |
| entRdData | output | 64 | Current value of the selected entry |
| eoiValid | input | 1 | End-of-interrupt broadcast strobe |
| eoiVector | input | 8 | Vector carried by the broadcast |
| msgValid | output | 1 | Message offered |
| msgReady | input | 1 | Receiver takes the message |
| msgAddr | output | 32 | Message address |
| msgData | output | 32 | Message data |

## Verification
A table of edge requests covers assorted destinations, destination modes, delivery modes and vectors, including all-ones and single-bit fields, so that any misplaced address or data field shows up as a wrong word. The level tests hold a line high across several end-of-interrupt broadcasts, one with a vector that does not match and one that does. This separates coalescing, re-arming and release of the line. Two simultaneous edges with ready held low show both the priority order and stability during a stall. A masked edge and a masked level request show the different fates of requests that arrive while the pin is masked.

// File: rtl/irqsvc_pkg.sv
`timescale 1ns/1ps
package irqsvc_pkg;
  // entry field positions (fixed layout decoded by software)
  localparam int VEC_LSB   = 0;
  localparam int VEC_W     = 8;
  localparam int DLV_LSB   = 8;
  localparam int DLV_W     = 3;
  localparam int DMODE_BIT = 11;
  localparam int RACK_BIT  = 14;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 48;
  localparam int DEST_W    = 16;
  localparam int ENTRY_W   = 64;

  // bits software may write: vector, delivery, dest mode, polarity, trigger, mask, destination
  localparam logic [ENTRY_W-1:0] RW_MASK     = 64'hFFFF_0000_0001_AFFF;
  localparam logic [ENTRY_W-1:0] RESET_ENTRY = 64'h0000_0000_0001_0000;
  localparam logic [31:0]        MSG_BASE    = 32'hFEE0_0000;
  localparam int                 ADDR_DEST_LSB  = 4;
  localparam int                 ADDR_DMODE_BIT = 2;
  localparam int                 DATA_TRIG_BIT  = 15;

  localparam int PIN_IDX_W = 8;

  typedef struct packed {
    logic                 load;  // latch a message for pin and apply its side effects
    logic [PIN_IDX_W-1:0] pin;
  } svcStrobes_t;
endpackage

// File: rtl/irqsvc_control.sv
`timescale 1ns/1ps
module irqsvc_control import irqsvc_pkg::*; #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] candVec,
  input  logic                msgReady,
  output logic                msgValid,
  output svcStrobes_t         strb
);
  logic                 anyCand;
  logic [PIN_IDX_W-1:0] lowPin;
  logic                 canLoad;

  // lowest-numbered deliverable pin wins
  always_comb begin
    lowPin = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (candVec[i]) lowPin = PIN_IDX_W'(i);
    end
  end

  assign anyCand   = |candVec;
  assign canLoad   = !msgValid || msgReady;
  assign strb.load = canLoad && anyCand;
  assign strb.pin  = lowPin;

  always_ff @(posedge clk) begin
    if (!rstN)        msgValid <= 1'b0;
    else if (canLoad) msgValid <= anyCand;
  end
endmodule

// File: rtl/irqsvc_datapath.sv
`timescale 1ns/1ps
module irqsvc_datapath import irqsvc_pkg::*; #(
  parameter int NUM_PINS   = 24,
  parameter int NUM_INPUTS = 32,
  parameter int IDX_W      = $clog2(NUM_PINS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_INPUTS-1:0] irqIn,
  input  logic [IDX_W-1:0]      entIdx,
  input  logic                  entWrEn,
  input  logic [ENTRY_W-1:0]    entWrData,
  output logic [ENTRY_W-1:0]    entRdData,
  input  logic                  eoiValid,
  input  logic [VEC_W-1:0]      eoiVector,
  input  svcStrobes_t           strb,
  output logic [NUM_PINS-1:0]   candVec,
  output logic [31:0]           msgAddr,
  output logic [31:0]           msgData
);
  logic [NUM_PINS-1:0]              pinLevel;
  logic [NUM_PINS-1:0][ENTRY_W-1:0] entryVec;

  // input steering: line 0 feeds pin 2, pin 0 has no source
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_steer
    if (p == 0) begin : g_p0
      assign pinLevel[p] = 1'b0;
    end else if (p == 2) begin : g_p2
      assign pinLevel[p] = irqIn[0] | irqIn[2];
    end else begin : g_pn
      assign pinLevel[p] = irqIn[p];
    end
  end

  if (NUM_INPUTS > NUM_PINS) begin : g_spare
    logic unusedLines;
    assign unusedLines = ^irqIn[NUM_INPUTS-1:NUM_PINS];
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [ENTRY_W-1:0] entQ, rwNext;
    logic pendQ, prevQ, wrHit, dlvHit, eoiHit, rackNext, rise;

    assign wrHit  = entWrEn && (entIdx == IDX_W'(p));
    assign dlvHit = strb.load && (strb.pin == PIN_IDX_W'(p));
    assign eoiHit = eoiValid && entQ[RACK_BIT] && (entQ[VEC_LSB +: VEC_W] == eoiVector);
    assign rise   = pinLevel[p] && !prevQ;
    assign rwNext = (wrHit ? entWrData : entQ) & RW_MASK;
    // acknowledge: set on level delivery, cleared by matching EOI or by edge mode
    assign rackNext = (entQ[RACK_BIT] | (dlvHit & entQ[TRIG_BIT])) & ~eoiHit & rwNext[TRIG_BIT];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entQ  <= RESET_ENTRY;
        pendQ <= 1'b0;
        prevQ <= 1'b0;
      end else begin
        entQ  <= rwNext | (ENTRY_W'(rackNext) << RACK_BIT);
        prevQ <= pinLevel[p];
        if (entQ[TRIG_BIT]) pendQ <= pinLevel[p];
        else                pendQ <= (pendQ & ~dlvHit) | (rise & ~entQ[MASK_BIT]);
      end
    end

    assign entryVec[p] = entQ;
    assign candVec[p]  = pendQ && !entQ[MASK_BIT] && !entQ[RACK_BIT];
  end

  always_comb begin
    entRdData = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (entIdx == IDX_W'(i)) entRdData = entryVec[i];
    end
  end

  // message fields of the selected pin
  logic [VEC_W-1:0]  selVec;
  logic [DLV_W-1:0]  selDlv;
  logic [DEST_W-1:0] selDest;
  logic              selDmode, selTrig;

  always_comb begin
    selVec = '0; selDlv = '0; selDest = '0; selDmode = 1'b0; selTrig = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (strb.pin == PIN_IDX_W'(i)) begin
        selVec   = entryVec[i][VEC_LSB +: VEC_W];
        selDlv   = entryVec[i][DLV_LSB +: DLV_W];
        selDest  = entryVec[i][DEST_LSB +: DEST_W];
        selDmode = entryVec[i][DMODE_BIT];
        selTrig  = entryVec[i][TRIG_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgAddr <= '0;
      msgData <= '0;
    end else if (strb.load) begin
      msgAddr <= MSG_BASE | (32'(selDest) << ADDR_DEST_LSB) | (32'(selDmode) << ADDR_DMODE_BIT);
      msgData <= (32'(selTrig) << DATA_TRIG_BIT) | (32'(selDlv) << DLV_LSB) | 32'(selVec);
    end
  end
endmodule

// File: rtl/irqsvc_engine.sv
`timescale 1ns/1ps
module irqsvc_engine import irqsvc_pkg::*; #(
  parameter int NUM_PINS   = 24,
  parameter int NUM_INPUTS = 32,
  localparam int IDX_W     = $clog2(NUM_PINS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_INPUTS-1:0] irqIn,
  input  logic [IDX_W-1:0]      entIdx,
  input  logic                  entWrEn,
  input  logic [63:0]           entWrData,
  output logic [63:0]           entRdData,
  input  logic                  eoiValid,
  input  logic [7:0]            eoiVector,
  output logic                  msgValid,
  input  logic                  msgReady,
  output logic [31:0]           msgAddr,
  output logic [31:0]           msgData
);
  svcStrobes_t         strb;
  logic [NUM_PINS-1:0] candVec;

  irqsvc_datapath #(.NUM_PINS(NUM_PINS), .NUM_INPUTS(NUM_INPUTS), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .entIdx(entIdx), .entWrEn(entWrEn),
    .entWrData(entWrData), .entRdData(entRdData), .eoiValid(eoiValid),
    .eoiVector(eoiVector), .strb(strb), .candVec(candVec),
    .msgAddr(msgAddr), .msgData(msgData)
  );

  irqsvc_control #(.NUM_PINS(NUM_PINS)) i_ctl (
    .clk(clk), .rstN(rstN), .candVec(candVec), .msgReady(msgReady),
    .msgValid(msgValid), .strb(strb)
  );
endmodule

// File: rtl/irqsvc_checker.sv
`timescale 1ns/1ps
module irqsvc_checker #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [IDX_W-1:0] entIdx,
  input logic [63:0]      entRdData,
  input logic             eoiValid,
  input logic [7:0]       eoiVector,
  input logic             msgValid,
  input logic             msgReady,
  input logic [31:0]      msgAddr,
  input logic [31:0]      msgData
);
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgAddr) && $stable(msgData));

  p_addr_shape_r6: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgAddr[31:20] == 12'hFEE) && !msgAddr[3] && (msgAddr[1:0] == 2'b00));

  p_data_shape_r7: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgData[31:16] == 16'h0) && (msgData[14:11] == 4'h0));

  p_eoi_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    eoiValid && entRdData[14] && (entRdData[7:0] == eoiVector)
      |=> (entIdx != $past(entIdx)) || !entRdData[14]);

  p_edge_no_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    !entRdData[15] |-> !entRdData[14]);
endmodule

bind irqsvc_engine irqsvc_checker #(.IDX_W(IDX_W)) i_chk (
  .clk(clk), .rstN(rstN), .entIdx(entIdx), .entRdData(entRdData),
  .eoiValid(eoiValid), .eoiVector(eoiVector), .msgValid(msgValid),
  .msgReady(msgReady), .msgAddr(msgAddr), .msgData(msgData)
);

// File: tb/test_irqsvc_engine.sv
`timescale 1ns/1ps
module test_irqsvc_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic [4:0]  entIdx = '0;
  logic        entWrEn = 1'b0;
  logic [63:0] entWrData = '0;
  logic [63:0] entRdData;
  logic        eoiValid = 1'b0;
  logic [7:0]  eoiVector = '0;
  logic        msgValid;
  logic        msgReady = 1'b0;
  logic [31:0] msgAddr, msgData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  irqsvc_engine i_irqsvc_engine (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .entIdx(entIdx), .entWrEn(entWrEn),
    .entWrData(entWrData), .entRdData(entRdData), .eoiValid(eoiValid),
    .eoiVector(eoiVector), .msgValid(msgValid), .msgReady(msgReady),
    .msgAddr(msgAddr), .msgData(msgData)
  );

  typedef struct packed {
    logic [7:0]  line;
    logic [7:0]  pin;
    logic [7:0]  vec;
    logic [2:0]  dlv;
    logic        dmode;
    logic [15:0] dest;
  } row_t;

  localparam row_t TABLE [6] = '{
    '{8'd1,  8'd1,  8'h40, 3'd1, 1'b1, 16'h00A5},
    '{8'd4,  8'd4,  8'hFE, 3'd7, 1'b0, 16'hFFFF},
    '{8'd23, 8'd23, 8'h20, 3'd2, 1'b1, 16'h8001},
    '{8'd11, 8'd11, 8'h7C, 3'd4, 1'b0, 16'h1234},
    '{8'd2,  8'd2,  8'h99, 3'd5, 1'b1, 16'h0F0F},
    '{8'd0,  8'd2,  8'h31, 3'd0, 1'b0, 16'h0001}
  };

  function automatic logic [63:0] mkEntry(input logic [7:0] vec, input logic [2:0] dlv,
      input logic dmode, input logic trig, input logic mask, input logic [15:0] dest);
    return 64'(vec) | (64'(dlv) << 8) | (64'(dmode) << 11) | (64'(trig) << 15)
         | (64'(mask) << 16) | (64'(dest) << 48);
  endfunction

  function automatic logic [31:0] expAddr(input logic [15:0] dest, input logic dmode);
    return 32'hFEE0_0000 + (32'(dest) * 16) + (dmode ? 32'd4 : 32'd0);
  endfunction

  function automatic logic [31:0] expData(input logic [7:0] vec, input logic [2:0] dlv, input logic trig);
    return (trig ? 32'h8000 : 32'h0) + (32'(dlv) * 256) + 32'(vec);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeEntry(input int idx, input logic [63:0] d);
    @(negedge clk);
    entIdx = 5'(idx); entWrData = d; entWrEn = 1'b1;
    @(negedge clk);
    entWrEn = 1'b0;
  endtask

  task automatic readEntry(input int idx, output logic [63:0] v);
    entIdx = 5'(idx);
    #1;
    v = entRdData;
  endtask

  task automatic pulse(input logic [31:0] lines);
    @(negedge clk); irqIn = irqIn | lines;
    @(negedge clk); irqIn = irqIn & ~lines;
  endtask

  task automatic sendEoi(input logic [7:0] v);
    @(negedge clk); eoiValid = 1'b1; eoiVector = v;
    @(negedge clk); eoiValid = 1'b0;
  endtask

  task automatic takeMsg(output bit got, output logic [31:0] a, output logic [31:0] d);
    got = 0; a = '0; d = '0;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      if (msgValid) begin
        got = 1; a = msgAddr; d = msgData;
        msgReady = 1'b1;
        @(negedge clk);
        msgReady = 1'b0;
      end
    end
  endtask

  task automatic expectMsg(input string req, input logic [31:0] ea, input logic [31:0] ed);
    bit got; logic [31:0] a, d;
    takeMsg(got, a, d);
    check(got && a == ea && d == ed, req, {a, d}, {ea, ed});
  endtask

  task automatic expectQuiet(input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (msgValid) seen = 1;
    end
    check(!seen, req, 64'(seen), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    bit okAll, stable;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    okAll = 1;
    for (int i = 0; i < 24; i++) begin
      readEntry(i, v);
      if (v != 64'h0000_0000_0001_0000) okAll = 0;
    end
    check(okAll && !msgValid, "R1 reset entries", v, 64'h0000_0000_0001_0000);

    // R6/R7: table of edge requests
    for (int r = 0; r < 6; r++) begin
      writeEntry(TABLE[r].pin, mkEntry(TABLE[r].vec, TABLE[r].dlv, TABLE[r].dmode, 1'b0, 1'b0, TABLE[r].dest));
      pulse(32'(1) << TABLE[r].line);
      expectMsg("R6 R7 table message", expAddr(TABLE[r].dest, TABLE[r].dmode),
                expData(TABLE[r].vec, TABLE[r].dlv, 1'b0));
      writeEntry(TABLE[r].pin, mkEntry(8'h0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0));
    end

    // R2: line 0 steered to pin 2, pin 0 gets nothing; high lines ignored
    writeEntry(0, mkEntry(8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
    writeEntry(2, mkEntry(8'h31, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
    pulse(32'h1);
    expectMsg("R2 line0 to pin2", expAddr(16'h0, 1'b0), expData(8'h31, 3'd0, 1'b0));
    expectQuiet(6, "R2 pin0 silent");
    pulse(32'hFF00_0000);
    expectQuiet(6, "R2 lines beyond pins ignored");
    writeEntry(0, mkEntry(8'h0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0));
    writeEntry(2, mkEntry(8'h0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0));

    // R3: masked edge dropped, unmasked edge delivered once
    writeEntry(9, mkEntry(8'h19, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0009));
    pulse(32'h200);
    expectQuiet(4, "R3 masked edge");
    writeEntry(9, mkEntry(8'h19, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0009));
    expectQuiet(6, "R3 masked edge not remembered");
    pulse(32'h200);
    expectMsg("R3 edge delivered", expAddr(16'h0009, 1'b0), expData(8'h19, 3'd0, 1'b0));
    expectQuiet(6, "R3 single edge message");
    writeEntry(9, mkEntry(8'h0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0));

    // R4/R5: level coalescing and end-of-interrupt
    writeEntry(5, mkEntry(8'h41, 3'd0, 1'b1, 1'b1, 1'b0, 16'h0055));
    @(negedge clk); irqIn[5] = 1'b1;
    expectMsg("R4 level delivered", expAddr(16'h0055, 1'b1), expData(8'h41, 3'd0, 1'b1));
    readEntry(5, v);
    check(v[14], "R4 ack set", 64'(v[14]), 64'd1);
    expectQuiet(10, "R4 coalesced");
    sendEoi(8'h42);
    expectQuiet(6, "R5 other vector no effect");
    readEntry(5, v);
    check(v[14], "R5 ack kept on other vector", 64'(v[14]), 64'd1);
    sendEoi(8'h41);
    expectMsg("R5 redelivered after eoi", expAddr(16'h0055, 1'b1), expData(8'h41, 3'd0, 1'b1));
    @(negedge clk); irqIn[5] = 1'b0;
    sendEoi(8'h41);
    expectQuiet(6, "R4 low input clears pending");
    readEntry(5, v);
    check(!v[14], "R5 ack cleared", 64'(v[14]), 64'd0);
    writeEntry(5, mkEntry(8'h0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0));

    // R10: masked level kept pending
    writeEntry(7, mkEntry(8'h77, 3'd3, 1'b0, 1'b1, 1'b1, 16'h0707));
    @(negedge clk); irqIn[7] = 1'b1;
    expectQuiet(6, "R10 masked level quiet");
    writeEntry(7, mkEntry(8'h77, 3'd3, 1'b0, 1'b1, 1'b0, 16'h0707));
    expectMsg("R10 delivered on unmask", expAddr(16'h0707, 1'b0), expData(8'h77, 3'd3, 1'b1));
    @(negedge clk); irqIn[7] = 1'b0;
    sendEoi(8'h77);
    writeEntry(7, mkEntry(8'h0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0));

    // R8: priority and stall
    writeEntry(3,  mkEntry(8'h33, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0003));
    writeEntry(10, mkEntry(8'h3A, 3'd0, 1'b0, 1'b0, 1'b0, 16'h000A));
    pulse(32'h408);
    stable = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i >= 2 && (!msgValid || msgData != expData(8'h33, 3'd0, 1'b0))) stable = 0;
    end
    check(stable, "R8 stall holds lowest pin", 64'(msgData), 64'(expData(8'h33, 3'd0, 1'b0)));
    expectMsg("R8 first lowest pin", expAddr(16'h0003, 1'b0), expData(8'h33, 3'd0, 1'b0));
    expectMsg("R8 second pin", expAddr(16'h000A, 1'b0), expData(8'h3A, 3'd0, 1'b0));
    writeEntry(3,  mkEntry(8'h0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0));
    writeEntry(10, mkEntry(8'h0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0));

    // R9: read-only and reserved bits, edge write clears ack
    writeEntry(12, 64'hFFFF_FFFF_FFFF_FFFF);
    readEntry(12, v);
    check(v == 64'hFFFF_0000_0001_AFFF, "R9 writable bits", v, 64'hFFFF_0000_0001_AFFF);
    writeEntry(12, mkEntry(8'h55, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0));
    @(negedge clk); irqIn[12] = 1'b1;
    expectMsg("R9 level setup", expAddr(16'h0, 1'b0), expData(8'h55, 3'd0, 1'b1));
    writeEntry(12, mkEntry(8'h56, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0));
    readEntry(12, v);
    check(v[14], "R9 ack survives write", 64'(v[14]), 64'd1);
    @(negedge clk); irqIn[12] = 1'b0;
    @(negedge clk);
    writeEntry(12, mkEntry(8'h56, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
    readEntry(12, v);
    check(!v[14], "R9 edge write clears ack", 64'(v[14]), 64'd0);
    expectQuiet(4, "R9 no stray message");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule